// File: doc/BRIEF.md
# Byte-Lane Asynchronous SRAM Responder

This block stands in for a 16-bit asynchronous static memory inside a clocked design. A fast internal clock samples the memory-side strobes: an active-low chip select, write strobe and output enable, and one active-low enable per byte lane. The same clock samples the address and the write data. The bidirectional data bus is split into an input vector, an output vector and one drive-enable bit per byte lane, so that a pad ring or a bus model can build the tri-state pins from them.

For every sampled cycle the block decodes whether the part is in standby, reading, writing or idle. During a read it drives only the lanes that are enabled. A write is the overlap of chip select, write strobe and a lane's enable. When any of these three drops out of the overlap, that lane stores the data and address that were present in the last sampled cycle of the overlap. The array depth is a parameter, and address bits above the array's index width are ignored. A standby output reports that chip select is inactive.

Top module: `sram_lane_responder`

## Requirements
- R1: With chip select low, write strobe high and output enable low, every lane whose enable is low drives the stored byte of the addressed word. Lane 0 is enabled by bit 0 of the lane enables and carries data bits 7:0. Lane 1 is enabled by bit 1 and carries bits 15:8. A driven lane has its drive-enable bit at 1.
- R2: During such a read, a lane whose enable is high has its drive-enable bit at 0.
- R3: With chip select and write strobe both low, only the lanes whose enable is low are updated. The value of output enable makes no difference to the write.
- R4: With chip select low, both drive-enable bits are 0 when both lane enables are high, or when write strobe and output enable are both high.
- R5: With chip select high, standby is 1 and both drive-enable bits are 0. A write strobe and lane enables applied in this state leave the array unchanged.
- R6: A lane's write commits when chip select, write strobe or that lane's enable goes inactive, whichever comes first. The lane stores the data and address sampled in the last cycle of the overlap. Data presented together with the terminating edge is not stored.
- R7: While a write is in progress, both drive-enable bits are 0, even with output enable low.
- R8: Outputs reflect the inputs that were sampled two rising clock edges earlier. An address change during a read is visible after the second rising edge and not after the first.
- R9: Only the low log2(DEPTH) address bits select a word. A write to an address above the depth lands on the word given by those low bits.
- R10: During and straight after reset, standby is 1 and both drive-enable bits are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Internal sampling clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| we_n | input | 1 | Write strobe, active low |
| oe_n | input | 1 | Output enable, active low |
| be_n | input | 2 | Lane enables, active low; bit 0 selects lane 0 |
| addr | input | 18 | Word address |
| dq_in | input | 16 | Write data from the bus |
| dq_out | output | 16 | Read data toward the bus |
| dq_oe | output | 2 | Per-lane drive enable for dq_out |
| standby | output | 1 | High while chip select is inactive |

## Verification
The assertions assume that the strobes are held steady between sampling edges, and that an output observed at an edge is meaningful only after two post-reset edges have filled the sample stages. A warm-up counter enforces the second point. The stimulus changes every input on the falling clock edge only. It holds each strobe pattern for at least two rising edges before the outputs are sampled, and it returns to an idle, deselected state between writes, so that every overlap has one clear termination.

// File: rtl/slr_pkg.sv
// Shared definitions for the byte-lane SRAM responder.
// Assumes strobes are active low and already synchronous to the sampling clock.
package slr_pkg;

    typedef enum logic [1:0] {
        MODE_STANDBY = 2'd0,
        MODE_IDLE    = 2'd1,
        MODE_READ    = 2'd2,
        MODE_WRITE   = 2'd3
    } slr_mode_e;

    // Classify one sampled strobe set; byte lanes are handled per lane elsewhere.
    function automatic slr_mode_e slr_decode(input logic cs_n, input logic we_n, input logic oe_n);
        if (cs_n)       return MODE_STANDBY;
        else if (!we_n) return MODE_WRITE;
        else if (!oe_n) return MODE_READ;
        else            return MODE_IDLE;
    endfunction

endpackage

// File: rtl/slr_sample_pipe.sv
// Two-stage sampling register for the packed strobe/address/data vector.
// Stage "cur" is the latest sample and stage "prev" the one before it.
// Assumes the inputs change only away from the rising edge of clk.
module slr_sample_pipe #(
    parameter int           W       = 8,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] cur,
    output logic [W-1:0] prev
);

    // Shift the sampled vector through two stages; reset loads the idle pattern.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur  <= RST_VAL;
            prev <= RST_VAL;
        end else begin
            cur  <= d;
            prev <= cur;
        end
    end

endmodule

// File: rtl/slr_lane_store.sv
// One byte lane of the storage array, with a synchronous write port and a
// registered read port. The array contents are not reset.
module slr_lane_store #(
    parameter int DEPTH  = 256,
    parameter int LANE_W = 8,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [LANE_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [LANE_W-1:0] rd_data
);

    logic [LANE_W-1:0] mem [DEPTH];

    // Commit a byte when the lane's write overlap has ended.
    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_idx] <= wr_data;
    end

    // Register the addressed byte; this stage is the address access latency.
    always_ff @(posedge clk) begin
        if (!rst_n) rd_data <= '0;
        else        rd_data <= mem[rd_idx];
    end

endmodule

// File: rtl/sram_lane_responder.sv
// Clocked stand-in for an asynchronous byte-lane static memory.
// It samples active-low strobes, decodes the mode of each cycle, drives only
// the enabled lanes during reads, and commits each lane's write when its
// overlap of chip select, write strobe and lane enable ends.
// Assumes DEPTH is a power of two smaller than 2**ADDR_W, and that the inputs
// are steady around the rising edge of clk.
module sram_lane_responder
    import slr_pkg::*;
#(
    parameter int ADDR_W = 18,
    parameter int LANES  = 2,
    parameter int LANE_W = 8,
    parameter int DEPTH  = 256
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cs_n,
    input  logic                    we_n,
    input  logic                    oe_n,
    input  logic [LANES-1:0]        be_n,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [LANES*LANE_W-1:0] dq_in,
    output logic [LANES*LANE_W-1:0] dq_out,
    output logic [LANES-1:0]        dq_oe,
    output logic                    standby
);

    localparam int DATA_W = LANES * LANE_W;
    localparam int IDX_W  = $clog2(DEPTH);
    localparam int IDX_LO = DATA_W;
    localparam int BE_LO  = IDX_LO + IDX_W;
    localparam int OE_BIT = BE_LO + LANES;
    localparam int WE_BIT = OE_BIT + 1;
    localparam int CS_BIT = WE_BIT + 1;
    localparam int SAMP_W = CS_BIT + 1;
    localparam logic [SAMP_W-1:0] IDLE_VEC = {3'b111, {LANES{1'b1}}, {(IDX_W + DATA_W){1'b0}}};

    logic [SAMP_W-1:0] raw_vec;
    logic [SAMP_W-1:0] cur_vec;
    logic [SAMP_W-1:0] prev_vec;
    slr_mode_e         cur_mode;
    logic              standby_q;
    logic              unused_bits;

    assign raw_vec  = {cs_n, we_n, oe_n, be_n, addr[IDX_W-1:0], dq_in};
    assign cur_mode = slr_decode(cur_vec[CS_BIT], cur_vec[WE_BIT], cur_vec[OE_BIT]);

    // Collect the bits that no stage consumes: upper address and stale fields.
    assign unused_bits = ^{addr[ADDR_W-1:IDX_W], prev_vec[OE_BIT], cur_vec[DATA_W-1:0]};

    slr_sample_pipe #(
        .W       (SAMP_W),
        .RST_VAL (IDLE_VEC)
    ) u_pipe (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (raw_vec),
        .cur   (cur_vec),
        .prev  (prev_vec)
    );

    for (genvar ln = 0; ln < LANES; ln++) begin : g_lane
        logic act_cur;
        logic act_prev;
        logic commit;
        logic oe_q;

        assign act_cur  = ~cur_vec[CS_BIT]  & ~cur_vec[WE_BIT]  & ~cur_vec[BE_LO + ln];
        assign act_prev = ~prev_vec[CS_BIT] & ~prev_vec[WE_BIT] & ~prev_vec[BE_LO + ln];
        assign commit   = act_prev & ~act_cur;

        slr_lane_store #(
            .DEPTH  (DEPTH),
            .LANE_W (LANE_W)
        ) u_store (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (commit),
            .wr_idx  (prev_vec[IDX_LO +: IDX_W]),
            .wr_data (prev_vec[ln*LANE_W +: LANE_W]),
            .rd_idx  (cur_vec[IDX_LO +: IDX_W]),
            .rd_data (dq_out[ln*LANE_W +: LANE_W])
        );

        // Drive this lane only for a read with its lane enable active.
        always_ff @(posedge clk) begin
            if (!rst_n) oe_q <= 1'b0;
            else        oe_q <= (cur_mode == MODE_READ) && !cur_vec[BE_LO + ln];
        end

        assign dq_oe[ln] = oe_q;
    end

    // Report standby aligned with the lane drive enables.
    always_ff @(posedge clk) begin
        if (!rst_n) standby_q <= 1'b1;
        else        standby_q <= (cur_mode == MODE_STANDBY);
    end

    assign standby = standby_q;

endmodule

// File: rtl/slr_checker.sv
// Port-level checker for the byte-lane SRAM responder, bound to every instance.
// Assumes the strobes are stable around rising edges. A warm-up counter holds
// off the two-cycle-deep checks until both sample stages hold post-reset data.
module slr_checker #(
    parameter int LANES = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cs_n,
    input logic             we_n,
    input logic             oe_n,
    input logic [LANES-1:0] be_n,
    input logic [LANES-1:0] dq_oe,
    input logic             standby
);

    logic [1:0] warm_cnt;
    logic       warm;

    // Count rising edges since reset was released, saturating at two.
    always_ff @(posedge clk) begin
        if (!rst_n)              warm_cnt <= 2'd0;
        else if (warm_cnt != 2'd2) warm_cnt <= warm_cnt + 2'd1;
    end

    assign warm = (warm_cnt == 2'd2);

    assert_standby_follows_cs_R5: assert property (@(posedge clk) disable iff (!rst_n)
        warm |-> (standby == $past(cs_n, 2)));

    assert_quiet_in_standby_R5: assert property (@(posedge clk) disable iff (!rst_n)
        standby |-> (dq_oe == '0));

    assert_float_during_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (warm && !$past(cs_n, 2) && !$past(we_n, 2)) |-> (dq_oe == '0));

    assert_read_lanes_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (warm && !$past(cs_n, 2) && $past(we_n, 2) && !$past(oe_n, 2))
            |-> (dq_oe == ~$past(be_n, 2)));

    assert_idle_float_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (warm && $past(we_n, 2) && $past(oe_n, 2)) |-> (dq_oe == '0));

endmodule

bind sram_lane_responder slr_checker #(.LANES(LANES)) u_slr_checker (
    .clk     (clk),
    .rst_n   (rst_n),
    .cs_n    (cs_n),
    .we_n    (we_n),
    .oe_n    (oe_n),
    .be_n    (be_n),
    .dq_oe   (dq_oe),
    .standby (standby)
);

// File: tb/sram_lane_responder_bench.sv
// Sweep bench for the byte-lane SRAM responder: writes every word with rotating
// termination styles and lane patterns, then reads every word with every lane
// combination, comparing against a model computed in the bench.
module sram_lane_responder_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1;
    logic        we_n = 1'b1;
    logic        oe_n = 1'b1;
    logic [1:0]  be_n = 2'b11;
    logic [17:0] addr = '0;
    logic [15:0] dq_in = '0;
    logic [15:0] dq_out;
    logic [1:0]  dq_oe;
    logic        standby;

    int n_cmp = 0;
    int n_bad = 0;
    logic [15:0] model [256];

    always #5 clk = ~clk;

    sram_lane_responder u_sram_lane_responder (
        .clk     (clk),
        .rst_n   (rst_n),
        .cs_n    (cs_n),
        .we_n    (we_n),
        .oe_n    (oe_n),
        .be_n    (be_n),
        .addr    (addr),
        .dq_in   (dq_in),
        .dq_out  (dq_out),
        .dq_oe   (dq_oe),
        .standby (standby)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic go_idle();
        @(negedge clk);
        cs_n = 1'b1; we_n = 1'b1; oe_n = 1'b1; be_n = 2'b11;
        @(negedge clk);
        @(negedge clk);
    endtask

    // Write with a chosen terminating strobe: 0 write strobe, 1 chip select, 2 lane enables.
    task automatic do_write(input logic [17:0] a, input logic [15:0] d, input logic [1:0] be,
                            input int term, input logic oe);
        @(negedge clk);
        addr = a; dq_in = d; be_n = be; oe_n = oe; cs_n = 1'b0; we_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk("R7 lanes float during write", {30'd0, dq_oe}, 32'd0);
        @(negedge clk);
        dq_in = ~d;  // R6: data changed with the terminating edge must not be stored
        if (term == 0)      we_n = 1'b1;
        else if (term == 1) cs_n = 1'b1;
        else                be_n = 2'b11;
        @(negedge clk);
        @(negedge clk);
        if (!be[0]) model[a[7:0]][7:0]  = d[7:0];
        if (!be[1]) model[a[7:0]][15:8] = d[15:8];
        go_idle();
    endtask

    task automatic do_read(input logic [17:0] a, input logic [1:0] be);
        @(negedge clk);
        addr = a; be_n = be; cs_n = 1'b0; we_n = 1'b1; oe_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk("R1/R2 lane drive enables", {30'd0, dq_oe}, {30'd0, ~be});
        if (!be[0]) chk("R1 low lane data", {24'd0, dq_out[7:0]}, {24'd0, model[a[7:0]][7:0]});
        if (!be[1]) chk("R1 high lane data", {24'd0, dq_out[15:8]}, {24'd0, model[a[7:0]][15:8]});
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin : main
        repeat (2) @(negedge clk);
        chk("R10 standby in reset", {31'd0, standby}, 32'd1);
        chk("R10 no drive in reset", {30'd0, dq_oe}, 32'd0);
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R10 standby after reset", {31'd0, standby}, 32'd1);
        chk("R10 no drive after reset", {30'd0, dq_oe}, 32'd0);

        // R3/R6: full-word fill, rotating termination and output enable.
        for (int a = 0; a < 256; a++) begin
            do_write(18'(a), {8'(a) ^ 8'hC3, 8'(a)}, 2'b00, a % 3, a[0]);
        end
        // R3/R6: partial lane writes over the fill.
        for (int a = 0; a < 256; a++) begin
            logic [1:0] be;
            be = (a % 3 == 0) ? 2'b10 : (a % 3 == 1) ? 2'b01 : 2'b00;
            do_write(18'(a), {8'(a + 17), 8'(a * 3)}, be, (a / 3) % 3, a[1]);
        end
        // R1/R2: read every word with every lane combination.
        for (int a = 0; a < 256; a++) begin
            do_read(18'(a), 2'(a % 4));
        end
        go_idle();

        // R5: strobes in standby are ignored and nothing drives.
        @(negedge clk);
        addr = 18'd7; dq_in = 16'h0000; be_n = 2'b00; we_n = 1'b0; oe_n = 1'b0; cs_n = 1'b1;
        repeat (3) @(negedge clk);
        chk("R5 standby asserted", {31'd0, standby}, 32'd1);
        chk("R5 no drive in standby", {30'd0, dq_oe}, 32'd0);
        go_idle();
        do_read(18'd7, 2'b00);  // R5: word 7 unchanged

        // R4: selected but both lanes off, then selected with strobes idle.
        @(negedge clk);
        cs_n = 1'b0; we_n = 1'b1; oe_n = 1'b0; be_n = 2'b11;
        repeat (2) @(negedge clk);
        chk("R4 both lanes off float", {30'd0, dq_oe}, 32'd0);
        chk("R4 not standby when selected", {31'd0, standby}, 32'd0);
        oe_n = 1'b1; be_n = 2'b00;
        repeat (2) @(negedge clk);
        chk("R4 we and oe high float", {30'd0, dq_oe}, 32'd0);
        go_idle();

        // R9: high address bits alias onto the low index.
        do_write(18'h2A1C3, 16'hBEEF, 2'b00, 0, 1'b1);
        do_read(18'h000C3, 2'b00);
        chk("R9 aliased word", {16'd0, dq_out}, 32'h0000BEEF);

        // R8: address change shows after the second edge, not the first.
        do_read(18'd10, 2'b00);
        @(negedge clk);
        addr = 18'd20;
        @(negedge clk);
        chk("R8 old data after one edge", {16'd0, dq_out}, {16'd0, model[10]});
        @(negedge clk);
        chk("R8 new data after two edges", {16'd0, dq_out}, {16'd0, model[20]});
        go_idle();

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule